// File: doc/BRIEF.md
# Interval Timer Channel with Compare Interrupt

This block is one timer channel built around a 32-bit up-counter. Software programs it through a small register bus. It raises a sticky status flag when the count meets a compare value, and it masks that flag onto an interrupt line. The counter only advances on cycles where the `tick` strobe is high, so a prescaler elsewhere sets the count rate.

In interval mode the channel works as a one-shot match detector or as a periodic tick generator. With the wrap option set, the counter returns to zero after each match and the interrupt repeats every `CMPA+1` ticks. Without it, the counter parks on the compare value. A watchdog mode selection changes which bits stop and clear the counter. The timer output pin is held low.

The register bus is plain control traffic, not a stream. A write is accepted on every cycle in which `bus_wr` is high, so it needs no valid/ready handshake and the block never applies back-pressure. Reads are combinational from `bus_addr`. Register map, by word address: 0 CTRL (bit0 RUN, bit1 CLR_STOP, bits[3:2] MODE), 1 CMPA, 2 STAT (bit0 FLAG), 3 IMASK (bit0 IE, bit1 WRAP), 4 COUNT (read-only), 5 WDCTL (bit0 WD_OFF). Unused addresses and unused bits read 0.

Top module: `interval_timer`

## Requirements
- R1: Outside watchdog mode, COUNT increases by exactly one at each clock edge where `tick`=1, RUN=1 and the counter is neither halted nor matching. At every other edge with no clear, it holds its value.
- R2: With RUN=0 and CLR_STOP=1 (not watchdog mode), COUNT is 0 from the next edge onward. With RUN=0 and CLR_STOP=0, COUNT keeps its value.
- R3: Reading address 4 returns the current count at any time. A write to address 4 changes nothing.
- R4: MODE=00 selects interval mode and MODE=10 selects watchdog mode. Compare matches are detected only in interval mode. CTRL reads back what was written.
- R5: A match occurs at an edge where, in interval mode, RUN=1, `tick`=1, the counter is not halted and COUNT equals CMPA. A match sets FLAG (STAT bit0) at that edge, and FLAG stays set until software clears it.
- R6: `irq` is high exactly while FLAG=1 and IE=1.
- R7: A write to STAT with bit0=0 clears FLAG. A write with bit0=1 leaves it unchanged. If a match occurs at the same edge as a clearing write, FLAG stays 1.
- R8: With WRAP=1, a match loads COUNT with 0 at that edge and counting goes on. The match then repeats every CMPA+1 ticks.
- R9: With WRAP=0, a match halts the counter at CMPA and no further match occurs. The halt ends on a write to CTRL or CMPA, or when RUN=0.
- R10: `timer_out` is 0 at all times.
- R11: In watchdog mode RUN has no effect. With WD_OFF=0 the counter advances on each `tick`. With WD_OFF=1 it is 0 from the next edge and holds there.
- R12: After reset every register reads 0, and both `irq` and `timer_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count-rate strobe from the prescaler |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Masked compare interrupt |
| timer_out | output | 1 | Timer output pin, held low |

## Verification
The assertions assume that `tick`, `bus_wr` and `bus_addr` hold stable, known values around each rising edge, and that only one register is written per cycle. They also assume that a clear at the count's own edge takes priority over counting. The bench changes every input at the falling edge and samples half a cycle later, so no input moves near an active edge. It issues a single write per cycle. The one deliberate overlap is a tick and a STAT write at the same edge, which exercises the match-wins rule.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_CMPA  = 3'd1,
    A_STAT  = 3'd2,
    A_IMASK = 3'd3,
    A_COUNT = 3'd4,
    A_WDCTL = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    M_INTERVAL = 2'b00,
    M_PULSE    = 2'b01,
    M_WATCHDOG = 2'b10,
    M_RSVD     = 2'b11
  } mode_e;

  typedef struct packed {
    logic  run;
    logic  clr_stop;
    mode_e mode;
    logic  ie;
    logic  wrap;
    logic  wd_off;
  } cfg_t;
endpackage

// File: rtl/timer_regs.sv
module timer_regs
  import timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              flag,
  output cfg_t              cfg,
  output logic [CNT_W-1:0]  cmpa,
  output logic              cfg_wr,
  output logic              stat_clr,
  output logic [CNT_W-1:0]  bus_rdata
);
  localparam int PAD = CNT_W - 4;

  logic wr_ctrl, wr_cmpa, wr_stat, wr_imask, wr_wd;

  always_comb begin
    wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    wr_cmpa  = bus_wr && (bus_addr == A_CMPA);
    wr_stat  = bus_wr && (bus_addr == A_STAT);
    wr_imask = bus_wr && (bus_addr == A_IMASK);
    wr_wd    = bus_wr && (bus_addr == A_WDCTL);
  end

  assign cfg_wr   = wr_ctrl || wr_cmpa;
  assign stat_clr = wr_stat && !bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg  <= '0;
      cmpa <= '0;
    end else begin
      if (wr_ctrl) begin
        cfg.run      <= bus_wdata[0];
        cfg.clr_stop <= bus_wdata[1];
        cfg.mode     <= mode_e'(bus_wdata[3:2]);
      end
      if (wr_cmpa)  cmpa       <= bus_wdata;
      if (wr_imask) begin
        cfg.ie   <= bus_wdata[0];
        cfg.wrap <= bus_wdata[1];
      end
      if (wr_wd)    cfg.wd_off <= bus_wdata[0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata = {{PAD{1'b0}}, cfg.mode, cfg.clr_stop, cfg.run};
      A_CMPA:  bus_rdata = cmpa;
      A_STAT:  bus_rdata[0] = flag;
      A_IMASK: bus_rdata[1:0] = {cfg.wrap, cfg.ie};
      A_COUNT: bus_rdata = cnt;
      A_WDCTL: bus_rdata[0] = cfg.wd_off;
      default: bus_rdata = '0;
    endcase
  end

  // R3: the count register accepts no writes, so a write there leaves the compare value alone
  assert_count_ro_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_COUNT) |=> $stable(cmpa));
endmodule

// File: rtl/timer_core.sv
module timer_core
  import timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  cfg_t             cfg,
  input  logic [CNT_W-1:0] cmpa,
  input  logic             cfg_wr,
  input  logic             stat_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             flag
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic wd_mode, iv_mode, go, clr, hit, halted;

  always_comb begin
    wd_mode = (cfg.mode == M_WATCHDOG);
    iv_mode = (cfg.mode == M_INTERVAL);
    go      = wd_mode ? !cfg.wd_off : cfg.run;
    clr     = wd_mode ? cfg.wd_off : (!cfg.run && cfg.clr_stop);
    hit     = iv_mode && cfg.run && tick && !halted && (cnt == cmpa);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (hit) begin
      if (cfg.wrap) cnt <= '0;
    end else if (go && tick && !halted) begin
      cnt <= cnt + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        halted <= 1'b0;
    else if (!cfg.run || cfg_wr || clr) halted <= 1'b0;
    else if (hit && !cfg.wrap)         halted <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (hit)      flag <= 1'b1;
    else if (stat_clr) flag <= 1'b0;
  end

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt));

  assert_stop_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_mode && !cfg.run && cfg.clr_stop) |=> (cnt == '0));

  assert_match_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !stat_clr) |=> flag);

  assert_wrap_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cfg.wrap) |=> (cnt == '0));

  assert_halt_park_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !cfg.wrap && !clr) |=> (cnt == $past(cnt)));

  assert_wd_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_mode && cfg.wd_off) |=> (cnt == '0));

  assert_no_match_outside_iv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!iv_mode && !flag) |=> !flag);
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq,
  output logic              timer_out
);
  cfg_t             cfg;
  logic [CNT_W-1:0] cmpa, cnt;
  logic             cfg_wr, stat_clr, flag;

  timer_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cnt(cnt), .flag(flag), .cfg(cfg), .cmpa(cmpa),
    .cfg_wr(cfg_wr), .stat_clr(stat_clr), .bus_rdata(bus_rdata)
  );

  timer_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(cfg), .cmpa(cmpa),
    .cfg_wr(cfg_wr), .stat_clr(stat_clr), .cnt(cnt), .flag(flag)
  );

  assign irq       = flag && cfg.ie;
  assign timer_out = 1'b0;

  // R6: a clearing write with no match drops the interrupt on the following cycle
  assert_irq_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !(tick && cnt == cmpa)) |=> !irq);
endmodule

// File: tb/interval_timer_test.sv
module interval_timer_test;
  localparam int N = 49;
  localparam logic [1:0] W = 2'd0, R = 2'd1, T = 2'd2, I = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, timer_out;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  interval_timer uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .timer_out(timer_out)
  );

  // entry: {op, addr, data, expected}; T/I use data as cycle count
  localparam logic [68:0] VEC [N] = '{
    {W, 3'd1, 32'd5, 32'd0},
    {W, 3'd3, 32'd3, 32'd0},
    {W, 3'd0, 32'd1, 32'd0},
    {T, 3'd0, 32'd3, 32'd0},
    {R, 3'd4, 32'd0, 32'd3},   // R1 three ticks
    {I, 3'd0, 32'd4, 32'd0},
    {R, 3'd4, 32'd0, 32'd3},   // R1 hold without tick
    {T, 3'd0, 32'd2, 32'd0},
    {R, 3'd2, 32'd0, 32'd0},   // R5 no match yet
    {T, 3'd0, 32'd1, 32'd0},
    {R, 3'd4, 32'd0, 32'd0},   // R8 wrap to zero
    {R, 3'd2, 32'd0, 32'd1},   // R5 flag set
    {T, 3'd0, 32'd4, 32'd0},
    {R, 3'd4, 32'd0, 32'd4},   // R8 keeps counting
    {W, 3'd2, 32'd1, 32'd0},
    {R, 3'd2, 32'd0, 32'd1},   // R7 write 1 no effect
    {W, 3'd2, 32'd0, 32'd0},
    {R, 3'd2, 32'd0, 32'd0},   // R7 write 0 clears
    {W, 3'd3, 32'd1, 32'd0},
    {T, 3'd0, 32'd1, 32'd0},
    {T, 3'd0, 32'd3, 32'd0},
    {R, 3'd4, 32'd0, 32'd5},   // R9 parked at compare
    {R, 3'd2, 32'd0, 32'd1},   // R9 match seen
    {W, 3'd2, 32'd0, 32'd0},
    {T, 3'd0, 32'd3, 32'd0},
    {R, 3'd2, 32'd0, 32'd0},   // R9 no rematch
    {R, 3'd4, 32'd0, 32'd5},   // R9 still parked
    {W, 3'd0, 32'd0, 32'd0},
    {I, 3'd0, 32'd1, 32'd0},
    {R, 3'd4, 32'd0, 32'd5},   // R2 hold on stop
    {W, 3'd0, 32'd2, 32'd0},
    {I, 3'd0, 32'd1, 32'd0},
    {R, 3'd4, 32'd0, 32'd0},   // R2 clear on stop
    {W, 3'd4, 32'h99, 32'd0},
    {R, 3'd4, 32'd0, 32'd0},   // R3 read-only count
    {W, 3'd0, 32'd8, 32'd0},
    {R, 3'd0, 32'd0, 32'd8},   // R4 mode readback
    {W, 3'd1, 32'd3, 32'd0},
    {T, 3'd0, 32'd5, 32'd0},
    {R, 3'd4, 32'd0, 32'd5},   // R11 run ignored
    {R, 3'd2, 32'd0, 32'd0},   // R4 no match in watchdog
    {W, 3'd5, 32'd1, 32'd0},
    {I, 3'd0, 32'd1, 32'd0},
    {R, 3'd4, 32'd0, 32'd0},   // R11 disable clears
    {T, 3'd0, 32'd2, 32'd0},
    {R, 3'd4, 32'd0, 32'd0},   // R11 held at zero
    {W, 3'd5, 32'd0, 32'd0},
    {T, 3'd0, 32'd2, 32'd0},
    {R, 3'd4, 32'd0, 32'd2}    // R11 counts again
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic ticks(input int n, input logic t);
    @(negedge clk);
    tick = t;
    for (int k = 0; k < n; k++) @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_wr = 1'b0; tick = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [31:0] v;
    do_reset();
    // R12 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      check("R12", v, 32'd0);
    end
    check("R12 irq", {31'd0, irq}, 32'd0);
    check("R10", {31'd0, timer_out}, 32'd0);

    for (int i = 0; i < N; i++) begin
      case (VEC[i][68:67])
        W: wr(VEC[i][66:64], VEC[i][63:32]);
        T: ticks(int'(VEC[i][63:32]), 1'b1);
        I: ticks(int'(VEC[i][63:32]), 1'b0);
        default: begin
          rd(VEC[i][66:64], v);
          check($sformatf("vector %0d", i), v, VEC[i][31:0]);
        end
      endcase
    end
    check("R10", {31'd0, timer_out}, 32'd0);

    // R6 interrupt masking
    do_reset();
    wr(3'd1, 32'd2);
    wr(3'd0, 32'd1);
    ticks(3, 1'b1);
    rd(3'd2, v);
    check("R6 flag", v, 32'd1);
    check("R6 masked", {31'd0, irq}, 32'd0);
    wr(3'd3, 32'd1);
    check("R6 enabled", {31'd0, irq}, 32'd1);
    wr(3'd2, 32'd0);
    check("R6 cleared", {31'd0, irq}, 32'd0);
    check("R10", {31'd0, timer_out}, 32'd0);

    // R7 match and clearing write at the same edge
    do_reset();
    wr(3'd1, 32'd3);
    wr(3'd3, 32'd2);
    wr(3'd0, 32'd1);
    ticks(4, 1'b1);
    ticks(3, 1'b1);
    rd(3'd4, v);
    check("R8 period", v, 32'd3);
    @(negedge clk);
    tick = 1'b1; bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 32'd0;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0; bus_wr = 1'b0;
    rd(3'd2, v);
    check("R7 match wins", v, 32'd1);
    rd(3'd4, v);
    check("R8 wrap", v, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule